// File: doc/BRIEF.md
# Banked Masked Control Register File

This block holds the system control registers of a small multithreaded core. A register is named by a 5-bit register number and a 3-bit select. The two combine into one flat slot number, number*8+select. Each implemented slot belongs to one of three banking classes:

- **shared**: a single copy.
- **per virtual processor**: one copy per VPE.
- **per thread context**: one copy per thread.

Every access carries the requesting thread ID, and the block uses it to pick the bank. Per-thread registers are indexed by the thread ID directly. Per-VPE registers are indexed by the VPE number held in that thread's own binding register.

Software writes are merged through a fixed per-register write mask, so read-only fields keep their stored value. After each such write the block raises a one-cycle pulse that tells downstream logic the control state changed. A separate raw write port, meant for updates from inside the hardware, stores the full word with no masking. Reads are combinational.

Reset first clears every bank to zero and then loads a few fixed values.

Top module: `ctlreg_file`

## Requirements
- R1: A slot is addressed as num*8+sel. A slot with no implemented register reads as 0. Writes to it from either port change nothing, and a software write to it raises no pulse.
- R2: A software write stores (wdata & mask) | (old & ~mask). The masks are: Index (0,0) 0x7FFFFFFF, EntryLo0 (2,0) and EntryLo1 (3,0) 0x3FFFFFFF, Context (4,0) 0xFF800000, PageMask (5,0) 0x1FFFF800, Status (12,0) 0xFF78FF17, IntCtl (12,1) 0x000003E0, SRSCtl (12,2) 0x0000F3C0, Cause (13,0) 0x08C00300, EBase (15,1) 0x3FFFF000, Config (16,0) 0x7FFF0007. VPE control (1,1), thread status (2,1), thread bind (2,2) and thread halt (2,4) have an all-ones mask.
- R3: Random (1,0), BadVAddr (8,0), PRId (15,0), Config1 (16,1), Config3 (16,3) and LL-address (17,0) have a zero mask, so software writes leave them unchanged.
- R4: A raw write stores the whole word, including read-only bits. When both ports hit the same bank in one cycle, the raw write wins.
- R5: Thread status, thread bind, thread halt, Status and LL-address keep one copy per thread, selected by `tid`.
- R6: VPE control and EBase keep one copy per VPE. The copy is selected by bits [VPE_W-1:0] of the requesting thread's bind register (2,2). A value of N_VPE or more selects VPE 0.
- R7: Shared registers return and store the same copy whatever `tid` is.
- R8: After reset:
  - every thread's Status is 0x00400004 (ERL bit 2 and BEV bit 22 set);
  - Random is 63;
  - every VPE's EBase is 0x80000000;
  - every other bank is 0.
- R9: `cfg_changed` is high for exactly the one cycle after a clock edge that accepted a software write to an implemented slot, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tid | input | $clog2(N_TC) | Requesting thread for all three access paths |
| rd_num | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data (combinational) |
| sw_we | input | 1 | Software (masked) write enable |
| sw_num | input | 5 | Software write register number |
| sw_sel | input | 3 | Software write select |
| sw_wdata | input | 32 | Software write data |
| hw_we | input | 1 | Raw write enable |
| hw_num | input | 5 | Raw write register number |
| hw_sel | input | 3 | Raw write select |
| hw_wdata | input | 32 | Raw write data |
| cfg_changed | output | 1 | One-cycle pulse after an accepted software write |

## Verification
The assertions assume the following about the inputs:
- `tid` is always below N_TC and every input is known once reset is released.
- The write enables are held low during reset, so the first flagged edge only sees deliberate writes.
- The read-only hold check on PRId assumes that only the raw port may change it.

The stimulus keeps to these assumptions. It draws the thread ID from 0..N_TC-1 and drives every input from time zero. Its random addresses come from a pool of implemented slots plus a few empty ones, so the masked path, the raw path and the binding redirection all get exercised.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int DW          = 32;
    localparam int NUM_SHARED  = 14;
    localparam int NUM_VPEREG  = 2;
    localparam int NUM_TCREG   = 5;
    localparam int SH_AW       = $clog2(NUM_SHARED);
    localparam int VR_AW       = $clog2(NUM_VPEREG);
    localparam int TR_AW       = $clog2(NUM_TCREG);

    // local indices inside each class
    localparam int SH_RANDOM   = 1;
    localparam int SH_PRID     = 10;
    localparam int VR_EBASE    = 1;
    localparam int TR_BIND     = 1;
    localparam int TR_STATUS   = 3;

    localparam logic [DW-1:0] RST_RANDOM = 32'd63;
    localparam logic [DW-1:0] RST_EBASE  = 32'h8000_0000;
    localparam logic [DW-1:0] RST_STATUS = 32'h0040_0004;

    typedef enum logic [1:0] {BK_NONE, BK_SHARED, BK_VPE, BK_TC} bank_kind_e;

    typedef struct packed {
        bank_kind_e    kind;
        logic [3:0]    idx;
        logic [DW-1:0] mask;
    } reg_info_t;

    function automatic reg_info_t slot_info(input logic [7:0] flat);
        reg_info_t r;
        r = '{kind: BK_NONE, idx: 4'd0, mask: '0};
        unique case (flat)
            8'd0:   r = '{BK_SHARED, 4'd0,  32'h7FFF_FFFF}; // Index
            8'd8:   r = '{BK_SHARED, 4'd1,  32'h0000_0000}; // Random
            8'd9:   r = '{BK_VPE,    4'd0,  32'hFFFF_FFFF}; // VPE control
            8'd16:  r = '{BK_SHARED, 4'd2,  32'h3FFF_FFFF}; // EntryLo0
            8'd17:  r = '{BK_TC,     4'd0,  32'hFFFF_FFFF}; // thread status
            8'd18:  r = '{BK_TC,     4'd1,  32'hFFFF_FFFF}; // thread bind
            8'd20:  r = '{BK_TC,     4'd2,  32'hFFFF_FFFF}; // thread halt
            8'd24:  r = '{BK_SHARED, 4'd3,  32'h3FFF_FFFF}; // EntryLo1
            8'd32:  r = '{BK_SHARED, 4'd4,  32'hFF80_0000}; // Context
            8'd40:  r = '{BK_SHARED, 4'd5,  32'h1FFF_F800}; // PageMask
            8'd64:  r = '{BK_SHARED, 4'd6,  32'h0000_0000}; // BadVAddr
            8'd96:  r = '{BK_TC,     4'd3,  32'hFF78_FF17}; // Status
            8'd97:  r = '{BK_SHARED, 4'd7,  32'h0000_03E0}; // IntCtl
            8'd98:  r = '{BK_SHARED, 4'd8,  32'h0000_F3C0}; // SRSCtl
            8'd104: r = '{BK_SHARED, 4'd9,  32'h08C0_0300}; // Cause
            8'd120: r = '{BK_SHARED, 4'd10, 32'h0000_0000}; // PRId
            8'd121: r = '{BK_VPE,    4'd1,  32'h3FFF_F000}; // EBase
            8'd128: r = '{BK_SHARED, 4'd11, 32'h7FFF_0007}; // Config
            8'd129: r = '{BK_SHARED, 4'd12, 32'h0000_0000}; // Config1
            8'd131: r = '{BK_SHARED, 4'd13, 32'h0000_0000}; // Config3
            8'd136: r = '{BK_TC,     4'd4,  32'h0000_0000}; // LL-address
            default: r = '{kind: BK_NONE, idx: 4'd0, mask: '0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic [4:0] num,
    input  logic [2:0] sel,
    output reg_info_t  info
);
    // R1: flat slot = num*8 + sel
    logic [7:0] flat;
    assign flat = {num, sel};
    assign info = slot_info(flat);
endmodule

// File: rtl/ctlreg_merge.sv
module ctlreg_merge
    import ctlreg_pkg::*;
(
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] new_val,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] merged
);
    // R2: writable bits from new_val, read-only bits kept from old_val
    assign merged = (new_val & mask) | (old_val & ~mask);
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int N_TC  = 4,
    parameter int N_VPE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(N_TC)-1:0]  tid,
    input  logic [4:0]               rd_num,
    input  logic [2:0]               rd_sel,
    output logic [31:0]              rd_data,
    input  logic                     sw_we,
    input  logic [4:0]               sw_num,
    input  logic [2:0]               sw_sel,
    input  logic [31:0]              sw_wdata,
    input  logic                     hw_we,
    input  logic [4:0]               hw_num,
    input  logic [2:0]               hw_sel,
    input  logic [31:0]              hw_wdata,
    output logic                     cfg_changed
);
    localparam int TC_W  = $clog2(N_TC);
    localparam int VPE_W = $clog2(N_VPE);

    logic [DW-1:0] shr_q [NUM_SHARED];
    logic [DW-1:0] vpe_q [NUM_VPEREG][N_VPE];
    logic [DW-1:0] tc_q  [NUM_TCREG][N_TC];
    logic          chg_q;

    // three decoders: read, software write, raw write
    reg_info_t  port_info [3];
    logic [4:0] port_num  [3];
    logic [2:0] port_sel  [3];
    assign port_num[0] = rd_num; assign port_sel[0] = rd_sel;
    assign port_num[1] = sw_num; assign port_sel[1] = sw_sel;
    assign port_num[2] = hw_num; assign port_sel[2] = hw_sel;

    for (genvar p = 0; p < 3; p++) begin : g_dec
        ctlreg_decode u_dec (
            .num  (port_num[p]),
            .sel  (port_sel[p]),
            .info (port_info[p])
        );
    end

    reg_info_t rd_i, sw_i, hw_i;
    assign rd_i = port_info[0];
    assign sw_i = port_info[1];
    assign hw_i = port_info[2];

    // R6: VPE bank resolved through the requesting thread's bind register
    logic [VPE_W-1:0] bind_fld, cur_vpe;
    assign bind_fld = tc_q[TR_BIND][tid][VPE_W-1:0];
    assign cur_vpe  = (32'(bind_fld) < N_VPE) ? bind_fld : '0;

    function automatic logic [DW-1:0] fetch(input reg_info_t ri);
        case (ri.kind)
            BK_SHARED: return shr_q[ri.idx[SH_AW-1:0]];
            BK_VPE:    return vpe_q[ri.idx[VR_AW-1:0]][cur_vpe];
            BK_TC:     return tc_q[ri.idx[TR_AW-1:0]][tid];
            default:   return '0;
        endcase
    endfunction

    logic [DW-1:0] sw_old, sw_merged;
    always_comb begin
        rd_data = fetch(rd_i);
        sw_old  = fetch(sw_i);
    end

    ctlreg_merge u_merge (
        .old_val (sw_old),
        .new_val (sw_wdata),
        .mask    (sw_i.mask),
        .merged  (sw_merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // R8: clear everything, then apply the fixed reset values
            for (int i = 0; i < NUM_SHARED; i++) shr_q[i] <= '0;
            for (int i = 0; i < NUM_VPEREG; i++)
                for (int v = 0; v < N_VPE; v++) vpe_q[i][v] <= '0;
            for (int i = 0; i < NUM_TCREG; i++)
                for (int t = 0; t < N_TC; t++) tc_q[i][t] <= '0;
            shr_q[SH_RANDOM] <= RST_RANDOM;
            for (int v = 0; v < N_VPE; v++) vpe_q[VR_EBASE][v] <= RST_EBASE;
            for (int t = 0; t < N_TC; t++)  tc_q[TR_STATUS][t] <= RST_STATUS;
            chg_q <= 1'b0;
        end else begin
            chg_q <= sw_we && (sw_i.kind != BK_NONE);
            if (sw_we) begin
                case (sw_i.kind)
                    BK_SHARED: shr_q[sw_i.idx[SH_AW-1:0]] <= sw_merged;
                    BK_VPE:    vpe_q[sw_i.idx[VR_AW-1:0]][cur_vpe] <= sw_merged;
                    BK_TC:     tc_q[sw_i.idx[TR_AW-1:0]][tid] <= sw_merged;
                    default:   ;
                endcase
            end
            // R4: raw write placed last, so it wins on a shared target
            if (hw_we) begin
                case (hw_i.kind)
                    BK_SHARED: shr_q[hw_i.idx[SH_AW-1:0]] <= hw_wdata;
                    BK_VPE:    vpe_q[hw_i.idx[VR_AW-1:0]][cur_vpe] <= hw_wdata;
                    BK_TC:     tc_q[hw_i.idx[TR_AW-1:0]][tid] <= hw_wdata;
                    default:   ;
                endcase
            end
        end
    end

    assign cfg_changed = chg_q;

    logic hw_hits_prid;
    assign hw_hits_prid = hw_we && (hw_i.kind == BK_SHARED) && (32'(hw_i.idx) == SH_PRID);

    a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_changed |-> $past(sw_we));

    a_r1_empty_slot_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_i.kind == BK_NONE) |=> !cfg_changed);

    a_r2_ro_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |-> (((sw_merged ^ sw_old) & ~sw_i.mask) == '0));

    a_r3_prid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_hits_prid |=> $stable(shr_q[SH_PRID]));

endmodule

// File: tb/ctlreg_file_tb.sv
module ctlreg_file_tb;
    localparam int N_TC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tid = '0;
    logic [4:0]  rd_num = '0, sw_num = '0, hw_num = '0;
    logic [2:0]  rd_sel = '0, sw_sel = '0, hw_sel = '0;
    logic [31:0] sw_wdata = '0, hw_wdata = '0, rd_data;
    logic        sw_we = 1'b0, hw_we = 1'b0, cfg_changed;

    int vectors = 0;
    int errors  = 0;
    logic exp_chg = 1'b0;
    logic [31:0] mdl [int];

    always #4 clk = ~clk;

    ctlreg_file u_dut (
        .clk(clk), .rst_n(rst_n), .tid(tid),
        .rd_num(rd_num), .rd_sel(rd_sel), .rd_data(rd_data),
        .sw_we(sw_we), .sw_num(sw_num), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .hw_we(hw_we), .hw_num(hw_num), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
        .cfg_changed(cfg_changed)
    );

    // class: 0 none, 1 shared, 2 per-VPE, 3 per-thread
    function automatic void minfo(input int flat, output int cls, output logic [31:0] m);
        cls = 1; m = 32'h0;
        case (flat)
            0*8+0:  m = 32'h7FFF_FFFF;
            1*8+0:  m = 32'h0;
            1*8+1:  begin cls = 2; m = 32'hFFFF_FFFF; end
            2*8+0:  m = 32'h3FFF_FFFF;
            2*8+1, 2*8+2, 2*8+4: begin cls = 3; m = 32'hFFFF_FFFF; end
            3*8+0:  m = 32'h3FFF_FFFF;
            4*8+0:  m = 32'hFF80_0000;
            5*8+0:  m = 32'h1FFF_F800;
            8*8+0, 15*8+0, 16*8+1, 16*8+3: m = 32'h0;
            12*8+0: begin cls = 3; m = 32'hFF78_FF17; end
            12*8+1: m = 32'h0000_03E0;
            12*8+2: m = 32'h0000_F3C0;
            13*8+0: m = 32'h08C0_0300;
            15*8+1: begin cls = 2; m = 32'h3FFF_F000; end
            16*8+0: m = 32'h7FFF_0007;
            17*8+0: begin cls = 3; m = 32'h0; end
            default: cls = 0;
        endcase
    endfunction

    function automatic logic [31:0] mget(input int key);
        return mdl.exists(key) ? mdl[key] : 32'h0;
    endfunction

    function automatic int mkey(input int t, input int flat);
        int cls; logic [31:0] m; int bank;
        minfo(flat, cls, m);
        if (cls == 3)      bank = t;
        else if (cls == 2) bank = int'(mget((2*8+2)*16 + t) & 32'h1);
        else               bank = 0;
        return flat*16 + bank;
    endfunction

    function automatic logic [31:0] mread(input int t, input int flat);
        int cls; logic [31:0] m;
        minfo(flat, cls, m);
        return (cls == 0) ? 32'h0 : mget(mkey(t, flat));
    endfunction

    task automatic model_reset();
        mdl.delete();
        mdl[(1*8+0)*16] = 32'd63;
        for (int v = 0; v < 2; v++) mdl[(15*8+1)*16 + v] = 32'h8000_0000;
        for (int t = 0; t < N_TC; t++) mdl[(12*8+0)*16 + t] = 32'h0040_0004;
    endtask

    task automatic step(input int t, input int rn, input int rs,
                        input bit swe, input int swn, input int sws, input logic [31:0] swd,
                        input bit hwe, input int hwn, input int hws, input logic [31:0] hwd,
                        input string tag);
        int cls_s, cls_h, ks, kh; logic [31:0] ms, mh, nv;
        @(negedge clk);
        tid = 2'(t); rd_num = 5'(rn); rd_sel = 3'(rs);
        sw_we = swe; sw_num = 5'(swn); sw_sel = 3'(sws); sw_wdata = swd;
        hw_we = hwe; hw_num = 5'(hwn); hw_sel = 3'(hws); hw_wdata = hwd;
        #1;
        vectors++;
        if (rd_data !== mread(t, rn*8+rs)) begin
            errors++;
            $display("FAIL %s rd_data t=%0d slot=(%0d,%0d) actual=%h expected=%h",
                     tag, t, rn, rs, rd_data, mread(t, rn*8+rs));
        end
        if (cfg_changed !== exp_chg) begin
            errors++;
            $display("FAIL R9 cfg_changed (%s) actual=%b expected=%b", tag, cfg_changed, exp_chg);
        end
        minfo(swn*8+sws, cls_s, ms);
        minfo(hwn*8+hws, cls_h, mh);
        ks = mkey(t, swn*8+sws);
        kh = mkey(t, hwn*8+hws);
        nv = (swd & ms) | (mread(t, swn*8+sws) & ~ms);
        @(posedge clk); #1;
        if (swe && cls_s != 0) mdl[ks] = nv;
        if (hwe && cls_h != 0) mdl[kh] = hwd;
        exp_chg = swe && (cls_s != 0);
    endtask

    task automatic rd(input int t, input int rn, input int rs, input string tag);
        step(t, rn, rs, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic sw(input int t, input int n, input int s, input logic [31:0] d, input string tag);
        step(t, n, s, 1, n, s, d, 0, 0, 0, 0, tag);
    endtask

    task automatic hw(input int t, input int n, input int s, input logic [31:0] d, input string tag);
        step(t, n, s, 0, 0, 0, 0, 1, n, s, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    int pool [24] = '{0, 8, 9, 16, 17, 18, 20, 24, 32, 40, 64, 96, 97, 98,
                      104, 120, 121, 128, 129, 131, 136, 255, 59, 7};

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8 reset values
        for (int t = 0; t < N_TC; t++) rd(t, 12, 0, "R8 status reset");
        rd(0, 1, 0, "R8 random reset");
        rd(0, 15, 1, "R8 ebase reset");
        rd(1, 0, 0, "R8 index reset");
        // R2 masked merge
        sw(1, 12, 0, 32'hFFFF_FFFF, "R2 status write");
        rd(1, 12, 0, "R2 status merged");
        sw(0, 13, 0, 32'hFFFF_FFFF, "R2 cause write");
        rd(0, 13, 0, "R2 cause merged");
        sw(0, 15, 1, 32'h0000_0000, "R2 ebase write");
        rd(0, 15, 1, "R2 ebase bit31 kept");
        // R3 read-only
        sw(0, 15, 0, 32'hDEAD_BEEF, "R3 prid write");
        rd(0, 15, 0, "R3 prid unchanged");
        sw(2, 1, 0, 32'h0000_0001, "R3 random write");
        rd(2, 1, 0, "R3 random unchanged");
        // R4 raw write
        hw(0, 15, 0, 32'h1234_5678, "R4 raw prid");
        rd(0, 15, 0, "R4 raw prid stored");
        step(0, 0, 0, 1, 0, 0, 32'h0000_00AA, 1, 0, 0, 32'h0000_0055, "R4 both ports");
        rd(0, 0, 0, "R4 raw wins");
        // R5 per-thread
        sw(2, 2, 4, 32'h0000_0001, "R5 halt t2");
        rd(0, 2, 4, "R5 halt t0 untouched");
        rd(2, 2, 4, "R5 halt t2 set");
        // R6 per-VPE through bind
        sw(3, 2, 2, 32'h0000_0001, "R6 bind t3 to vpe1");
        sw(3, 15, 1, 32'h0000_5000, "R6 ebase via t3");
        rd(0, 15, 1, "R6 ebase vpe0");
        rd(3, 15, 1, "R6 ebase vpe1");
        sw(3, 1, 1, 32'hCAFE_0001, "R6 vpectl via t3");
        rd(1, 1, 1, "R6 vpectl vpe0");
        // R7 shared
        sw(0, 4, 0, 32'hFFFF_FFFF, "R7 context write t0");
        rd(3, 4, 0, "R7 context seen by t3");
        // R1 empty slots
        sw(1, 31, 7, 32'hFFFF_FFFF, "R1 empty write");
        rd(1, 31, 7, "R1 empty reads zero");
        hw(1, 7, 3, 32'hFFFF_FFFF, "R1 empty raw write");
        rd(1, 7, 3, "R1 empty raw reads zero");
        rd(1, 0, 0, "R1 index intact");
        // R9 pulse ends after one cycle
        rd(0, 0, 0, "R9 pulse low");

        for (int i = 0; i < 4000; i++) begin
            int t, r, s, h;
            t = $urandom_range(0, 3);
            r = pool[$urandom_range(0, 23)];
            s = pool[$urandom_range(0, 23)];
            h = pool[$urandom_range(0, 23)];
            step(t, r / 8, r % 8, 1'($urandom_range(0, 1)), s / 8, s % 8, $urandom,
                 ($urandom_range(0, 3) == 0), h / 8, h % 8, $urandom, "R2/R5/R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule